// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block works out, one data phase at a time, the dword address a target must use during a burst on a 32-bit bus. A start strobe loads the first address together with a 2-bit ordering mode. Each pulse on the advance input marks one completed data phase and moves the generator to the next address. Addresses can step linearly, or visit the four dwords of a 16-byte cache line in an interleaved (XOR) order or in a wrapping order. After a full line in either of the last two orders, the line base moves up by 16 and the same offset pattern repeats.

A disconnect request tells the surrounding bus logic to end the burst after the current data phase. It is always raised in the single-transfer mode. When the coherency enable is high, it is also raised on the last beat of every cache line, so that no burst crosses a line boundary. A separate flag shows that the next address would fall into a different line. An advance while the disconnect request is up ends the burst: the address holds and the generator goes idle until the next start. Bus handshaking and the data path live outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: During reset and after it is released, the outputs read address 0, with disconnect, line-end and active all low.
- R2: A start strobe makes the block active. The address becomes the start address with bits 1:0 forced to zero, and the first beat of the line begins. The strobe takes effect on the next clock edge.
- R3: Mode 2'b00 (linear): each advance adds 4 to the address and crosses line boundaries freely (0x0C, 0x10, 0x14, 0x18, 0x1C, 0x20).
- R4: Mode 2'b01 (toggle): the dword index in the line is the start index XOR a 2-bit beat count. From 0x0C the order is 0x0C, 0x08, 0x04, 0x00, then 0x1C, 0x18 in the next line.
- R5: Mode 2'b10 (wrap): the dword index in the line is the start index plus the beat count, modulo 4. From 0x0C the order is 0x0C, 0x00, 0x04, 0x08, then 0x1C, 0x10.
- R6: While active, the line-end flag is high exactly when the next address lies in another 16-byte line. In linear mode this is when address bits 3:2 equal 3. In toggle and wrap mode it is on the fourth beat of each line. An advance taken there moves the line base up by 16.
- R7: Mode 2'b11 (single): the disconnect request is high while active, and one advance ends the burst.
- R8: With the coherency enable high, the disconnect request is high on the last beat of every line in every mode. An advance while the disconnect request is high clears active and holds the address.
- R9: An advance while idle has no effect: the address holds and active stays low.
- R10: A start strobe reloads the generator at any time, including mid-burst. When it arrives in the same cycle as an advance, the start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Load a new burst |
| start_addr_i | input | ADDR_W | Byte address of the first data phase |
| mode_i | input | 2 | Ordering mode: 00 linear, 01 toggle, 10 wrap, 11 single |
| coh_en_i | input | 1 | Force disconnect on the last beat of each cache line |
| adv_i | input | 1 | One data phase completed |
| addr_o | output | ADDR_W | Address of the current data phase |
| disc_o | output | 1 | Request to disconnect after the current data phase |
| line_end_o | output | 1 | Next address would leave the current cache line |
| active_o | output | 1 | A burst is in progress |

## Verification
The clash that matters most is a start strobe landing in the same cycle as an advance. The two fight over the same address registers. The bench first moves a linear burst one beat forward. It then drives a new start in a different mode with the advance held high. The address seen one edge later must be the new start address, not the next step of the old burst. Only the following plain advance may move it on, and that step must follow the new mode's order. A second overlap occurs when the coherency enable brings the disconnect request up in the same cycle as the line-end flag. The bench checks that both are set, and that the advance taken there ends the burst without moving the address.

// File: rtl/bas_pkg.sv
package bas_pkg;

  typedef enum logic [1:0] {
    BM_LINEAR = 2'b00,
    BM_TOGGLE = 2'b01,
    BM_WRAP   = 2'b10,
    BM_SINGLE = 2'b11
  } bmode_e;

endpackage

// File: rtl/bas_rst_sync.sv
module bas_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/bas_order.sv
module bas_order
  import bas_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  bmode_e             mode_i,
  input  logic [IDX_W-1:0]   sidx_i,
  input  logic [IDX_W-1:0]   beat_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               last_o
);

  localparam logic [IDX_W-1:0] IDX_TOP = '1;

  logic [IDX_W-1:0] idx_xor;
  logic [IDX_W-1:0] idx_add;

  assign idx_xor = sidx_i ^ beat_i;
  assign idx_add = sidx_i + beat_i;

  always_comb begin
    unique case (mode_i)
      BM_TOGGLE: begin
        idx_o  = idx_xor;
        last_o = (beat_i == IDX_TOP);
      end
      BM_WRAP: begin
        idx_o  = idx_add;
        last_o = (beat_i == IDX_TOP);
      end
      default: begin
        idx_o  = sidx_i;
        last_o = (sidx_i == IDX_TOP);
      end
    endcase
  end

endmodule

// File: rtl/bas_ctrl.sv
module bas_ctrl
  import bas_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = 2,
  parameter int BYTE_OFS = IDX_W + 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [ADDR_W-1:0]          start_addr_i,
  input  bmode_e                     mode_i,
  input  logic                       adv_i,
  input  logic                       disc_i,
  input  logic                       last_i,
  output logic                       active_o,
  output bmode_e                     mode_o,
  output logic [ADDR_W-1:BYTE_OFS]   base_o,
  output logic [IDX_W-1:0]           sidx_o,
  output logic [IDX_W-1:0]           beat_o
);

  localparam int LINE_W = ADDR_W - BYTE_OFS;

  logic                 active_q, active_d;
  bmode_e               mode_q, mode_d;
  logic [LINE_W-1:0]    base_q, base_d;
  logic [IDX_W-1:0]     sidx_q, sidx_d;
  logic [IDX_W-1:0]     beat_q, beat_d;
  logic                 step_en;
  logic                 ld_en;
  logic                 unused_lo;

  assign unused_lo = ^start_addr_i[1:0];
  assign step_en   = active_q & adv_i & ~start_i;
  assign ld_en     = start_i | step_en;

  always_comb begin
    active_d = active_q;
    mode_d   = mode_q;
    base_d   = base_q;
    sidx_d   = sidx_q;
    beat_d   = beat_q;
    if (start_i) begin
      active_d = 1'b1;
      mode_d   = mode_i;
      base_d   = start_addr_i[ADDR_W-1:BYTE_OFS];
      sidx_d   = start_addr_i[BYTE_OFS-1:2];
      beat_d   = '0;
    end else if (step_en) begin
      if (disc_i) begin
        active_d = 1'b0;
      end else begin
        if (mode_q == BM_LINEAR || mode_q == BM_SINGLE) begin
          sidx_d = sidx_q + 1'b1;
        end else begin
          beat_d = beat_q + 1'b1;
        end
        if (last_i) begin
          base_d = base_q + LINE_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      mode_q   <= BM_LINEAR;
      base_q   <= '0;
      sidx_q   <= '0;
      beat_q   <= '0;
    end else if (ld_en) begin
      active_q <= active_d;
      mode_q   <= mode_d;
      base_q   <= base_d;
      sidx_q   <= sidx_d;
      beat_q   <= beat_d;
    end
  end

  assign active_o = active_q;
  assign mode_o   = mode_q;
  assign base_o   = base_q;
  assign sidx_o   = sidx_q;
  assign beat_o   = beat_q;

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> active_q && base_q == $past(start_addr_i[ADDR_W-1:BYTE_OFS])
                && sidx_q == $past(start_addr_i[BYTE_OFS-1:2]) && beat_q == '0); // R2 R10

  AST_STOP_ON_DISC: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && adv_i && disc_i && !start_i |=> !active_q && $stable(base_q)); // R7 R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q && !start_i |=> !active_q && $stable(base_q) && $stable(sidx_q)); // R9

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LINE_DWORDS = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [1:0]        mode_i,
  input  logic              coh_en_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              disc_o,
  output logic              line_end_o,
  output logic              active_o
);

  localparam int IDX_W    = (LINE_DWORDS > 1) ? $clog2(LINE_DWORDS) : 1;
  localparam int BYTE_OFS = IDX_W + 2;
  localparam int LINE_W   = ADDR_W - BYTE_OFS;

  logic               rst_sync_n;
  logic               active;
  bmode_e             mode_q;
  logic [LINE_W-1:0]  base;
  logic [IDX_W-1:0]   sidx;
  logic [IDX_W-1:0]   beat;
  logic [IDX_W-1:0]   idx;
  logic               last;
  logic               disc;

  bas_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  bas_order #(
    .IDX_W (IDX_W)
  ) u_order (
    .mode_i (mode_q),
    .sidx_i (sidx),
    .beat_i (beat),
    .idx_o  (idx),
    .last_o (last)
  );

  bas_ctrl #(
    .ADDR_W   (ADDR_W),
    .IDX_W    (IDX_W),
    .BYTE_OFS (BYTE_OFS)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .start_i      (start_i),
    .start_addr_i (start_addr_i),
    .mode_i       (bmode_e'(mode_i)),
    .adv_i        (adv_i),
    .disc_i       (disc),
    .last_i       (last),
    .active_o     (active),
    .mode_o       (mode_q),
    .base_o       (base),
    .sidx_o       (sidx),
    .beat_o       (beat)
  );

  assign disc       = active & ((mode_q == BM_SINGLE) | (coh_en_i & last));
  assign addr_o     = {base, idx, 2'b00};
  assign disc_o     = disc;
  assign line_end_o = active & last;
  assign active_o   = active;

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    active && mode_q == BM_LINEAR && adv_i && !start_i && !disc_o
    |=> addr_o == $past(addr_o) + ADDR_W'(4)); // R3

  AST_IN_LINE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    active && (mode_q == BM_TOGGLE || mode_q == BM_WRAP) && adv_i && !start_i
    && !disc_o && !line_end_o
    |=> addr_o[ADDR_W-1:BYTE_OFS] == $past(addr_o[ADDR_W-1:BYTE_OFS])); // R4 R5

  AST_LINE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    active && adv_i && !start_i && !disc_o && line_end_o
    |=> addr_o[ADDR_W-1:BYTE_OFS] == $past(addr_o[ADDR_W-1:BYTE_OFS]) + LINE_W'(1)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !active_o |-> !disc_o && !line_end_o); // R1 R9

endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [31:0] start_addr_i;
  logic [1:0]  mode_i;
  logic        coh_en_i;
  logic        adv_i;
  logic [31:0] addr_o;
  logic        disc_o;
  logic        line_end_o;
  logic        active_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] q_addr[$];
  logic [2:0]  q_flag[$];
  string       q_tag[$];

  always #2 clk = ~clk;

  burst_addr_seq u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .start_addr_i (start_addr_i),
    .mode_i       (mode_i),
    .coh_en_i     (coh_en_i),
    .adv_i        (adv_i),
    .addr_o       (addr_o),
    .disc_o       (disc_o),
    .line_end_o   (line_end_o),
    .active_o     (active_o)
  );

  function automatic void compare(input logic [31:0] ea, input logic [2:0] ef, input string tag);
    logic [2:0] af;
    af = {active_o, disc_o, line_end_o};
    checks++;
    if (addr_o !== ea || af !== ef) begin
      errors++;
      $display("FAIL %s addr=%h exp=%h {act,disc,lend}=%b exp=%b", tag, addr_o, ea, af, ef);
    end
  endfunction

  // monitor: pops one expected item per clock, sampled 1 unit after the edge
  always @(posedge clk) begin
    #1;
    if (q_addr.size() > 0) begin
      compare(q_addr.pop_front(), q_flag.pop_front(), q_tag.pop_front());
    end
  end

  // driver: applies stimulus at the falling edge, expects result after next rise
  task automatic drive(input logic st, input logic [31:0] sa, input logic [1:0] md,
                       input logic coh, input logic adv,
                       input logic [31:0] ea, input logic [2:0] ef, input string tag);
    @(negedge clk);
    start_i      = st;
    start_addr_i = sa;
    mode_i       = md;
    coh_en_i     = coh;
    adv_i        = adv;
    q_addr.push_back(ea);
    q_flag.push_back(ef);
    q_tag.push_back(tag);
  endtask

  // reference order built from the requirement text
  function automatic logic [31:0] model_addr(input logic [1:0] md, input logic [31:0] sa, input int n);
    logic [31:0] line;
    logic [1:0]  si, b, off;
    if (md == 2'b00 || md == 2'b11) return (sa & ~32'h3) + 32'(4 * n);
    line = (sa & ~32'hF) + 32'(16 * (n / 4));
    si   = sa[3:2];
    b    = 2'(n % 4);
    off  = (md == 2'b01) ? (si ^ b) : (si + b);
    return line + {28'd0, off, 2'b00};
  endfunction

  function automatic logic model_lend(input logic [1:0] md, input logic [31:0] sa, input int n);
    logic [31:0] a;
    a = model_addr(md, sa, n);
    if (md == 2'b00 || md == 2'b11) return a[3:2] == 2'b11;
    return (n % 4) == 3;
  endfunction

  task automatic run_burst(input logic [1:0] md, input logic [31:0] sa, input logic coh,
                           input int beats, input string tag);
    for (int n = 0; n < beats; n++) begin
      logic l;
      l = model_lend(md, sa, n);
      drive((n == 0), sa, md, coh, (n != 0), model_addr(md, sa, n), {1'b1, coh & l, l}, tag);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; start_addr_i = '0; mode_i = 2'b00; coh_en_i = 1'b0; adv_i = 1'b0;
    repeat (3) @(negedge clk);
    compare(32'h0, 3'b000, "R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    drive(0, 32'h0, 2'b00, 0, 0, 32'h0, 3'b000, "R1 after release");

    // R2 / R3: low bits ignored, linear across a line
    drive(1, 32'h0000_100E, 2'b00, 0, 0, 32'h100C, 3'b101, "R2 R3 start linear");
    drive(0, 32'h0, 2'b00, 0, 1, 32'h1010, 3'b100, "R3 R6 linear");
    drive(0, 32'h0, 2'b00, 0, 1, 32'h1014, 3'b100, "R3 linear");
    drive(0, 32'h0, 2'b00, 0, 1, 32'h1018, 3'b100, "R3 linear");
    drive(0, 32'h0, 2'b00, 0, 1, 32'h101C, 3'b101, "R3 R6 linear");
    drive(0, 32'h0, 2'b00, 0, 1, 32'h1020, 3'b100, "R3 linear");

    // R4 toggle
    drive(1, 32'h200C, 2'b01, 0, 0, 32'h200C, 3'b100, "R4 toggle");
    drive(0, 32'h0, 2'b01, 0, 1, 32'h2008, 3'b100, "R4 toggle");
    drive(0, 32'h0, 2'b01, 0, 1, 32'h2004, 3'b100, "R4 toggle");
    drive(0, 32'h0, 2'b01, 0, 1, 32'h2000, 3'b101, "R4 R6 toggle");
    drive(0, 32'h0, 2'b01, 0, 1, 32'h201C, 3'b100, "R4 R6 toggle");
    drive(0, 32'h0, 2'b01, 0, 1, 32'h2018, 3'b100, "R4 toggle");

    // R5 wrap
    drive(1, 32'h400C, 2'b10, 0, 0, 32'h400C, 3'b100, "R5 wrap");
    drive(0, 32'h0, 2'b10, 0, 1, 32'h4000, 3'b100, "R5 wrap");
    drive(0, 32'h0, 2'b10, 0, 1, 32'h4004, 3'b100, "R5 wrap");
    drive(0, 32'h0, 2'b10, 0, 1, 32'h4008, 3'b101, "R5 R6 wrap");
    drive(0, 32'h0, 2'b10, 0, 1, 32'h401C, 3'b100, "R5 R6 wrap");
    drive(0, 32'h0, 2'b10, 0, 1, 32'h4010, 3'b100, "R5 wrap");

    // further offsets against the reference order
    run_burst(2'b01, 32'h3004, 0, 8, "R4 R6 toggle model");
    run_burst(2'b10, 32'h3108, 0, 8, "R5 R6 wrap model");
    run_burst(2'b00, 32'h33F8, 0, 6, "R3 R6 linear model");

    // R7 single transfer, then R9 idle advances
    drive(1, 32'h5008, 2'b11, 0, 0, 32'h5008, 3'b110, "R7 single");
    drive(0, 32'h0, 2'b00, 0, 1, 32'h5008, 3'b000, "R7 single ends");
    drive(0, 32'h0, 2'b00, 0, 1, 32'h5008, 3'b000, "R9 idle advance");
    drive(0, 32'h0, 2'b00, 1, 1, 32'h5008, 3'b000, "R9 idle advance");

    // R8 coherent stop at line end
    drive(1, 32'h6004, 2'b00, 1, 0, 32'h6004, 3'b100, "R8 coh linear");
    drive(0, 32'h0, 2'b00, 1, 1, 32'h6008, 3'b100, "R8 coh linear");
    drive(0, 32'h0, 2'b00, 1, 1, 32'h600C, 3'b111, "R8 coh linear last");
    drive(0, 32'h0, 2'b00, 1, 1, 32'h600C, 3'b000, "R8 coh linear ends");
    drive(1, 32'h7008, 2'b01, 1, 0, 32'h7008, 3'b100, "R8 coh toggle");
    drive(0, 32'h0, 2'b01, 1, 1, 32'h700C, 3'b100, "R8 coh toggle");
    drive(0, 32'h0, 2'b01, 1, 1, 32'h7000, 3'b100, "R8 coh toggle");
    drive(0, 32'h0, 2'b01, 1, 1, 32'h7004, 3'b111, "R8 coh toggle last");
    drive(0, 32'h0, 2'b01, 1, 1, 32'h7004, 3'b000, "R8 coh toggle ends");
    run_burst(2'b10, 32'h7104, 1, 4, "R8 coh wrap model");
    drive(0, 32'h0, 2'b10, 1, 1, 32'h7100, 3'b000, "R8 coh wrap ends");

    // R10 start beats a simultaneous advance, and reloads mid-burst
    drive(1, 32'h8000, 2'b00, 0, 0, 32'h8000, 3'b100, "R10 first burst");
    drive(0, 32'h0, 2'b00, 0, 1, 32'h8004, 3'b100, "R10 first burst");
    drive(1, 32'h9010, 2'b10, 0, 1, 32'h9010, 3'b100, "R10 start with advance");
    drive(0, 32'h0, 2'b10, 0, 1, 32'h9014, 3'b100, "R10 new mode steps");
    drive(1, 32'hA01C, 2'b01, 0, 0, 32'hA01C, 3'b100, "R10 reload mid-burst");
    drive(0, 32'h0, 2'b01, 0, 1, 32'hA018, 3'b100, "R10 reload mid-burst");

    drive(0, 32'h0, 2'b00, 0, 0, 32'hA018, 3'b100, "R9 hold without advance");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule